// File: doc/BRIEF.md
# Auxiliary System Control Registers

This block is a small set of memory-mapped housekeeping registers for a system controller. Seven storage locations each have their own chip-select. Five of them are byte-wide: configuration, diagnostic, modem control and two auxiliary bytes. There is also a 16-bit indicator-light word and a 32-bit system-control word. Reads return data combinationally. Writes take effect at the clock edge.

Some write bits do not store a value; they act. One bit of the first auxiliary byte fires a terminal-count pulse for a floppy controller. In the second auxiliary byte, one bit requests power-off and another clears the sticky power-fail status. In the system-control word, bit 0 requests a chip reset.

An asynchronous power-fail input is synchronised, then latched into a status bit. The status bit raises a level interrupt only while the configuration enable is set. A reset clears the control bytes but leaves the diagnostic, indicator and system-control contents intact.

Top module: `aux_sysctl`

## Requirements
- R1: `cs` bit positions select the registers: 0 configuration, 1 diagnostic, 2 modem control, 3 auxiliary-1, 4 auxiliary-2, 5 indicator word, 6 system-control word. The configuration, diagnostic and modem bytes store and read back a written byte in full, zero-extended on `rdata`.
- R2: `acc_size` codes are 0 for byte, 1 for 16-bit and 2 for 32-bit; code 3 is never valid. The byte registers require code 0, the indicator word code 1 and the system-control word code 2. An access with another code writes nothing and reads 0.
- R3: A valid auxiliary-1 write with bit 1 set makes `fdc_tc` high for exactly the one cycle after the write edge. Bit 1 is stored as 0 and bits 7..2 and 0 are stored as written.
- R4: An auxiliary-2 write keeps only bit 0 from the bus and reads back with bit 1 at 0. Bit 5 holds the power-fail status and survives the write unless bit 1 is written as 1, which clears it. The other bits read 0.
- R5: An auxiliary-2 write with bit 0 set stores bit 0 and pulses `pwroff_req` for one cycle.
- R6: The power-fail status is set when the synchronised `pwr_fail_async` rises while configuration bit 3 is set. It is cleared when the input falls. It is visible at most three clock edges after the input changes, and a rise with the enable clear leaves it at 0.
- R7: `irq` is high exactly when the status bit and configuration bit 3 are both set. It follows configuration writes, auxiliary-2 writes and input changes at the same edge as the status.
- R8: A 32-bit write at `offset` 0 with bit 0 set loads the system-control word with 0x02 and pulses `sysrst_req` for one cycle. A write at any other offset is ignored, and a read at any other offset returns 0.
- R9: While `rst_n` is low, the configuration, auxiliary-1, auxiliary-2 and modem registers are cleared and `irq` is 0.
- R10: The diagnostic byte, the indicator word and the system-control word keep their values through a reset.
- R11: The indicator word stores and returns all 16 written bits on a 16-bit access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 7 | One chip-select per register |
| wr_en | input | 1 | Write strobe; a selected cycle without it is a read |
| acc_size | input | 2 | Access width code |
| offset | input | 2 | Byte offset inside the system-control word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected register |
| pwr_fail_async | input | 1 | Asynchronous power-fail indication |
| irq | output | 1 | Power-fail interrupt level |
| fdc_tc | output | 1 | Floppy terminal-count pulse |
| pwroff_req | output | 1 | Power-off request pulse |
| sysrst_req | output | 1 | System reset request pulse |

## Verification
A corrupted status or enable flop shows up on `irq` at the next edge and on an auxiliary-2 read in the same cycle. A wrongly stored action bit is visible on the next read of auxiliary-1 or auxiliary-2. A missing or doubled pulse is seen on the side-effect outputs in the cycle after the write, or in the cycle after that. A size-decode fault is exposed at once on `rdata`, and after the next read of the register that a rejected write could have changed.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } acc_size_e;

   localparam int SEL_CFG   = 0;
   localparam int SEL_DIAG  = 1;
   localparam int SEL_MODEM = 2;
   localparam int SEL_AUX1  = 3;
   localparam int SEL_AUX2  = 4;
   localparam int SEL_LED   = 5;
   localparam int SEL_SYS   = 6;
   localparam int SEL_COUNT = 7;

   localparam int CFG_PFEN_BIT  = 3;
   localparam int AUX1_TC_BIT   = 1;
   localparam int AUX2_OFF_BIT  = 0;
   localparam int AUX2_CLR_BIT  = 1;
   localparam int AUX2_STAT_BIT = 5;
   localparam int SYS_RST_BIT   = 0;
   localparam logic [7:0] SYS_RST_STATUS = 8'h02;

   function automatic acc_size_e needed_size(input int idx);
      if (idx == SEL_LED) return SZ_HALF;
      if (idx == SEL_SYS) return SZ_WORD;
      return SZ_BYTE;
   endfunction
endpackage

// File: rtl/aux_access_decode.sv
module aux_access_decode
   import aux_sysctl_pkg::*;
#(
   parameter int N_SEL = SEL_COUNT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SEL-1:0] cs,
   input  logic             wr_en,
   input  logic [1:0]       acc_size,
   output logic [N_SEL-1:0] size_ok,
   output logic [N_SEL-1:0] wr_hit
);
   for (genvar i = 0; i < N_SEL; i++) begin : g_sel
      assign size_ok[i] = cs[i] && (acc_size == needed_size(i));
      assign wr_hit[i]  = size_ok[i] && wr_en && rst_n;
   end

   AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs)); // R1
endmodule

// File: rtl/aux_pf_sync.sv
module aux_pf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level,
   output logic changed
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level   = chain_q[STAGES-1];
   assign changed = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/aux_power_ctl.sv
module aux_power_ctl
   import aux_sysctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_wr,
   input  logic       aux2_wr,
   input  logic [7:0] wbyte,
   input  logic       pf_level,
   input  logic       pf_changed,
   output logic [7:0] cfg_q,
   output logic [7:0] aux2_q,
   output logic       irq,
   output logic       pwroff_req
);
   logic [7:0] cfg_n;
   logic [7:0] aux2_n;
   logic       irq_n;

   always_comb begin
      cfg_n  = cfg_wr ? wbyte : cfg_q;
      aux2_n = aux2_q;
      if (aux2_wr) begin
         aux2_n                = '0;
         aux2_n[AUX2_OFF_BIT]  = wbyte[AUX2_OFF_BIT];
         aux2_n[AUX2_STAT_BIT] = aux2_q[AUX2_STAT_BIT] & ~wbyte[AUX2_CLR_BIT];
      end
      if (pf_changed)
         aux2_n[AUX2_STAT_BIT] = pf_level & cfg_q[CFG_PFEN_BIT];
      irq_n = aux2_n[AUX2_STAT_BIT] & cfg_n[CFG_PFEN_BIT];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q      <= '0;
         aux2_q     <= '0;
         irq        <= 1'b0;
         pwroff_req <= 1'b0;
      end else begin
         cfg_q      <= cfg_n;
         aux2_q     <= aux2_n;
         irq        <= irq_n;
         pwroff_req <= aux2_wr & wbyte[AUX2_OFF_BIT];
      end
   end

   AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (aux2_q[AUX2_STAT_BIT] && cfg_q[CFG_PFEN_BIT])); // R7
   AST_STATUS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(aux2_q[AUX2_STAT_BIT]) |-> $past(cfg_q[CFG_PFEN_BIT])); // R6
   AST_PWROFF_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      pwroff_req |-> aux2_q[AUX2_OFF_BIT]); // R5
   AST_CLR_NOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(aux2_wr && wbyte[AUX2_CLR_BIT] && !pf_changed) |-> !aux2_q[AUX2_STAT_BIT]); // R4
endmodule

// File: rtl/aux_sysctl.sv
module aux_sysctl
   import aux_sysctl_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int LED_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SEL_COUNT-1:0] cs,
   input  logic                 wr_en,
   input  logic [1:0]           acc_size,
   input  logic [1:0]           offset,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   input  logic                 pwr_fail_async,
   output logic                 irq,
   output logic                 fdc_tc,
   output logic                 pwroff_req,
   output logic                 sysrst_req
);
   localparam int BYTE_W = 8;

   if (DATA_W < 32) begin : g_bad_data_w
      $error("DATA_W must be at least 32");
   end
   if (LED_W <= BYTE_W || LED_W > DATA_W) begin : g_bad_led_w
      $error("LED_W must lie between 9 and DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SEL_COUNT-1:0] size_ok, wr_hit;
   logic [BYTE_W-1:0]    wbyte;
   logic [BYTE_W-1:0]    cfg_q, aux2_q, diag_q, modem_q, aux1_q, sys_q;
   logic [LED_W-1:0]     led_q;
   logic                 pf_level, pf_changed;
   logic                 sys_hit, unused_hi;

   assign wbyte     = wdata[BYTE_W-1:0];
   assign sys_hit   = wr_hit[SEL_SYS] && (offset == 2'd0);
   assign unused_hi = ^wdata[DATA_W-1:LED_W];

   aux_access_decode #(.N_SEL(SEL_COUNT)) u_decode (
      .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en),
      .acc_size(acc_size), .size_ok(size_ok), .wr_hit(wr_hit));

   aux_pf_sync #(.STAGES(SYNC_STAGES)) u_pf_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pwr_fail_async),
      .level(pf_level), .changed(pf_changed));

   aux_power_ctl u_power (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(wr_hit[SEL_CFG]), .aux2_wr(wr_hit[SEL_AUX2]), .wbyte(wbyte),
      .pf_level(pf_level), .pf_changed(pf_changed),
      .cfg_q(cfg_q), .aux2_q(aux2_q), .irq(irq), .pwroff_req(pwroff_req));

   // Registers cleared by reset
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         modem_q <= '0;
         aux1_q  <= '0;
         fdc_tc  <= 1'b0;
      end else begin
         if (wr_hit[SEL_MODEM]) modem_q <= wbyte;
         if (wr_hit[SEL_AUX1]) begin
            aux1_q              <= wbyte;
            aux1_q[AUX1_TC_BIT] <= 1'b0;
         end
         fdc_tc <= wr_hit[SEL_AUX1] && wbyte[AUX1_TC_BIT];
      end
   end

   // Registers that survive reset (writes are gated off during reset)
   always_ff @(posedge clk) begin
      if (wr_hit[SEL_DIAG]) diag_q <= wbyte;
      if (wr_hit[SEL_LED])  led_q  <= wdata[LED_W-1:0];
      if (sys_hit && wdata[SYS_RST_BIT]) sys_q <= SYS_RST_STATUS;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sysrst_req <= 1'b0;
      else        sysrst_req <= sys_hit && wdata[SYS_RST_BIT];
   end

   always_comb begin
      rdata = '0;
      if (size_ok[SEL_CFG])   rdata = rdata | DATA_W'(cfg_q);
      if (size_ok[SEL_DIAG])  rdata = rdata | DATA_W'(diag_q);
      if (size_ok[SEL_MODEM]) rdata = rdata | DATA_W'(modem_q);
      if (size_ok[SEL_AUX1])  rdata = rdata | DATA_W'(aux1_q);
      if (size_ok[SEL_AUX2])  rdata = rdata | DATA_W'(aux2_q);
      if (size_ok[SEL_LED])   rdata = rdata | DATA_W'(led_q);
      if (size_ok[SEL_SYS] && offset == 2'd0) rdata = rdata | DATA_W'(sys_q);
   end

   AST_TC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      fdc_tc |-> $past(wr_hit[SEL_AUX1] && wbyte[AUX1_TC_BIT])); // R3
   AST_SYSRST_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      sysrst_req |-> (sys_q == SYS_RST_STATUS)); // R8
   AST_SYSRST_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      sysrst_req |-> $past(offset == 2'd0 && acc_size == SZ_WORD)); // R8
endmodule

// File: tb/aux_sysctl_bench.sv
module aux_sysctl_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  cs = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  acc_size = '0;
   logic [1:0]  offset = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        pwr_fail_async = 1'b0;
   logic        irq, fdc_tc, pwroff_req, sysrst_req;

   int n_checks = 0;
   int n_fail   = 0;

   logic [7:0]  m_cfg, m_diag, m_modem, m_aux1, m_aux2, m_sys;
   logic [15:0] m_led;
   logic        seen_tc, seen_off, seen_rst;

   always #(CLK_PERIOD/2) clk = ~clk;

   aux_sysctl u_aux_sysctl (
      .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .acc_size(acc_size),
      .offset(offset), .wdata(wdata), .rdata(rdata),
      .pwr_fail_async(pwr_fail_async), .irq(irq), .fdc_tc(fdc_tc),
      .pwroff_req(pwroff_req), .sysrst_req(sysrst_req));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   function automatic logic [1:0] size_for(input int idx);
      if (idx == 5) return 2'd1;
      if (idx == 6) return 2'd2;
      return 2'd0;
   endfunction

   // Expected stored values, from the requirements
   function automatic logic [7:0] aux1_store(input logic [7:0] w);
      return w & 8'hFD;
   endfunction

   function automatic logic [7:0] aux2_store(input logic [7:0] old, input logic [7:0] w);
      return {2'b00, old[5] & ~w[1], 4'b0000, w[0]};
   endfunction

   function automatic logic [31:0] expect_read(input int idx, input logic [1:0] sz,
                                                input logic [1:0] off);
      if (sz != size_for(idx)) return 32'h0;
      case (idx)
         0: return {24'h0, m_cfg};
         1: return {24'h0, m_diag};
         2: return {24'h0, m_modem};
         3: return {24'h0, m_aux1};
         4: return {24'h0, m_aux2};
         5: return {16'h0, m_led};
         default: return (off == 2'd0) ? {24'h0, m_sys} : 32'h0;
      endcase
   endfunction

   task automatic model_write(input int idx, input logic [1:0] sz, input logic [1:0] off,
                              input logic [31:0] d);
      if (sz != size_for(idx)) return;
      case (idx)
         0: m_cfg   = d[7:0];
         1: m_diag  = d[7:0];
         2: m_modem = d[7:0];
         3: m_aux1  = aux1_store(d[7:0]);
         4: m_aux2  = aux2_store(m_aux2, d[7:0]);
         5: m_led   = d[15:0];
         default: if (off == 2'd0 && d[0]) m_sys = 8'h02;
      endcase
   endtask

   task automatic bus_write(input int idx, input logic [1:0] sz, input logic [1:0] off,
                            input logic [31:0] d);
      @(negedge clk);
      cs = 7'(1 << idx); wr_en = 1'b1; acc_size = sz; offset = off; wdata = d;
      @(negedge clk);
      seen_tc = fdc_tc; seen_off = pwroff_req; seen_rst = sysrst_req;
      cs = '0; wr_en = 1'b0;
      model_write(idx, sz, off, d);
   endtask

   task automatic bus_read(input int idx, input logic [1:0] sz, input logic [1:0] off,
                           output logic [31:0] d);
      @(negedge clk);
      cs = 7'(1 << idx); wr_en = 1'b0; acc_size = sz; offset = off;
      #1 d = rdata;
      cs = '0;
   endtask

   task automatic check_read(input string req, input int idx, input logic [1:0] sz,
                             input logic [1:0] off);
      logic [31:0] d;
      bus_read(idx, sz, off, d);
      check(req, d, expect_read(idx, sz, off));
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_cfg = 8'h0; m_aux1 = 8'h0; m_aux2 = 8'h0; m_modem = 8'h0;
   endtask

   task automatic wait_sync();
      repeat (4) @(negedge clk);
      m_aux2[5] = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd20240611));
      m_diag = 8'h0; m_led = 16'h0; m_sys = 8'h0;
      do_reset();

      // R9: reset state
      check("R9 cfg", expect_read(0, 2'd0, 2'd0), 32'h0);
      check_read("R9 cfg", 0, 2'd0, 2'd0);
      check_read("R9 modem", 2, 2'd0, 2'd0);
      check_read("R9 aux1", 3, 2'd0, 2'd0);
      check_read("R9 aux2", 4, 2'd0, 2'd0);
      check("R9 irq", {31'h0, irq}, 32'h0);

      // R1, R11, R10: storage and survival through reset
      bus_write(1, 2'd0, 2'd0, 32'h5A5A_5AA5);
      bus_write(5, 2'd1, 2'd0, 32'hFFFF_C3E1);
      bus_write(6, 2'd2, 2'd0, 32'h0000_0001);
      check("R8 sysrst pulse", {31'h0, seen_rst}, 32'h1);
      bus_write(0, 2'd0, 2'd0, 32'h0000_00F7);
      bus_write(2, 2'd0, 2'd0, 32'h0000_0081);
      check_read("R1 cfg", 0, 2'd0, 2'd0);
      check_read("R1 modem", 2, 2'd0, 2'd0);
      check_read("R11 led", 5, 2'd1, 2'd0);
      do_reset();
      check_read("R10 diag kept", 1, 2'd0, 2'd0);
      check_read("R10 led kept", 5, 2'd1, 2'd0);
      check_read("R10 sys kept", 6, 2'd2, 2'd0);
      check_read("R9 cfg cleared", 0, 2'd0, 2'd0);

      // R3: terminal-count pulse
      bus_write(3, 2'd0, 2'd0, 32'h0000_00FF);
      check("R3 tc pulse", {31'h0, seen_tc}, 32'h1);
      @(negedge clk);
      check("R3 tc one cycle", {31'h0, fdc_tc}, 32'h0);
      check_read("R3 aux1 stored", 3, 2'd0, 2'd0);
      check("R3 aux1 value", expect_read(3, 2'd0, 2'd0), 32'hFD);

      // R4, R5: power-off
      bus_write(4, 2'd0, 2'd0, 32'h0000_00FF);
      check("R5 pwroff pulse", {31'h0, seen_off}, 32'h1);
      @(negedge clk);
      check("R5 pwroff one cycle", {31'h0, pwroff_req}, 32'h0);
      check_read("R4 aux2 stored", 4, 2'd0, 2'd0);

      // R6, R7: power-fail status with enable
      bus_write(0, 2'd0, 2'd0, 32'h0000_0008);
      bus_write(4, 2'd0, 2'd0, 32'h0000_0000);
      @(negedge clk); pwr_fail_async = 1'b1;
      repeat (4) @(negedge clk);
      m_aux2[5] = 1'b1;
      check_read("R6 status set", 4, 2'd0, 2'd0);
      check("R7 irq high", {31'h0, irq}, 32'h1);
      bus_write(0, 2'd0, 2'd0, 32'h0000_0000);
      check("R7 irq drops with enable", {31'h0, irq}, 32'h0);
      check_read("R7 status kept", 4, 2'd0, 2'd0);
      bus_write(0, 2'd0, 2'd0, 32'h0000_0008);
      check("R7 irq back", {31'h0, irq}, 32'h1);
      bus_write(4, 2'd0, 2'd0, 32'h0000_0000);
      check("R4 status kept on write", {31'h0, irq}, 32'h1);
      bus_write(4, 2'd0, 2'd0, 32'h0000_0002);
      check("R4 clear drops irq", {31'h0, irq}, 32'h0);
      check_read("R4 status cleared", 4, 2'd0, 2'd0);

      // R6: falling input clears status
      @(negedge clk); pwr_fail_async = 1'b0;
      wait_sync();
      @(negedge clk); pwr_fail_async = 1'b1;
      repeat (4) @(negedge clk);
      m_aux2[5] = 1'b1;
      check("R7 irq again", {31'h0, irq}, 32'h1);
      @(negedge clk); pwr_fail_async = 1'b0;
      wait_sync();
      check_read("R6 status cleared by fall", 4, 2'd0, 2'd0);
      check("R6 irq low after fall", {31'h0, irq}, 32'h0);

      // R6: rise with enable clear
      bus_write(0, 2'd0, 2'd0, 32'h0000_00F7);
      @(negedge clk); pwr_fail_async = 1'b1;
      repeat (4) @(negedge clk);
      check_read("R6 no status without enable", 4, 2'd0, 2'd0);
      bus_write(0, 2'd0, 2'd0, 32'h0000_0008);
      check("R6 no irq after late enable", {31'h0, irq}, 32'h0);
      @(negedge clk); pwr_fail_async = 1'b0;
      wait_sync();

      // R8: other offsets
      do_reset();
      bus_write(6, 2'd2, 2'd1, 32'h0000_0001);
      check("R8 no pulse off offset", {31'h0, seen_rst}, 32'h0);
      check_read("R8 offset 2 reads 0", 6, 2'd2, 2'd2);
      check_read("R8 offset 0 value", 6, 2'd2, 2'd0);

      // R2: wrong sizes
      bus_write(1, 2'd1, 2'd0, 32'h0000_0011);
      bus_write(5, 2'd0, 2'd0, 32'h0000_2222);
      bus_write(3, 2'd2, 2'd0, 32'h0000_0002);
      check("R2 no tc on bad size", {31'h0, seen_tc}, 32'h0);
      check_read("R2 diag unchanged", 1, 2'd0, 2'd0);
      check_read("R2 led unchanged", 5, 2'd1, 2'd0);
      check_read("R2 bad size read", 1, 2'd3, 2'd0);

      // Random mix (input held low, so the status stays 0)
      for (int it = 0; it < 400; it++) begin
         int          idx;
         logic [1:0]  sz, off;
         logic [31:0] dat;
         idx = int'($urandom % 7);
         sz  = (($urandom % 4) == 0) ? 2'($urandom % 4) : size_for(idx);
         off = (idx == 6) ? 2'($urandom % 4) : 2'd0;
         dat = $urandom;
         if ($urandom % 2 == 0) begin
            bus_write(idx, sz, off, dat);
            check("R3 random tc", {31'h0, seen_tc},
                  {31'h0, idx == 3 && sz == 2'd0 && dat[1]});
            check("R5 random pwroff", {31'h0, seen_off},
                  {31'h0, idx == 4 && sz == 2'd0 && dat[0]});
            check("R8 random sysrst", {31'h0, seen_rst},
                  {31'h0, idx == 6 && sz == 2'd2 && off == 2'd0 && dat[0]});
            check("R7 random irq", {31'h0, irq}, 32'h0);
         end else begin
            check_read("R1 R2 random read", idx, sz, off);
         end
      end
      summary();
   end
endmodule